// File: doc/BRIEF.md
# Widening multiply unit with overflow flags

The block multiplies two integer operands at a run-time width of 8, 16, 32 or 64 bits and forms the full double-width product. Each operation comes with a signedness bit and a keep-high bit. Signed operations take both factors as two's complement numbers of the selected width. Unsigned operations take both factors as plain magnitudes. For every operation the unit also sets a carry flag and an overflow flag. Both flags report whether the upper half of the product holds bits that matter.

Work arrives on a valid/ready request port. The unit accepts one operation at a time and holds `req_ready` low until the last result beat of that operation has been taken. The unit then works through the multiplier a few bits per clock. Results leave on a valid/ready stream that the consumer may stall: while `res_valid` is high and `res_ready` is low, the data beat and its last marker hold still.

- At widths above 8 with keep-high set, the product leaves as two beats: the low half, then the high half.
- At widths above 8 with keep-high clear, the unit sends the low half only. This serves the truncating two- and three-operand forms, where the second factor (for instance an immediate) arrives on `req_b`.
- At width 8 the whole 16-bit product fills one accumulator-style beat.

The flags change only when the final beat of an operation is first presented.

Top module: `wmul_unit`

## Requirements
- R1: A request is taken on a clock edge where `req_valid` and `req_ready` are both high. `req_ready` is high only while the unit is idle, so it is low from the cycle after acceptance until the final result beat has been taken, and it is never high while `res_valid` is high.
- R2: With `req_signed`=0, each operand is the low w bits of its port with zero extension, where w = 8 << `req_wsel` (codes 0, 1, 2, 3 give 8, 16, 32, 64). Port bits above w have no effect on the result.
- R3: With `req_signed`=1, each operand is sign-extended from bit w-1 and the product is the exact signed product; this includes the most negative value times -1.
- R4: With w > 8 and `req_keep_hi`=1, the unit sends two beats. The first has `res_last`=0 and data = product bits w-1..0. The second has `res_last`=1 and data = product bits 2w-1..w. In both beats, data bits above w are 0.
- R5: With w > 8 and `req_keep_hi`=0, the unit sends one beat with `res_last`=1 and data = product bits w-1..0. The flags are still computed from the full product.
- R6: With w = 8, the unit sends one beat with `res_last`=1, whatever `req_keep_hi` is. Data bits 15..0 hold the 16-bit product, with the high byte in bits 15..8, and data bits above 15 are 0.
- R7: In unsigned operations, `res_cf` and `res_of` are both 1 when the high half is nonzero, and both 0 otherwise.
- R8: In signed operations, `res_cf` and `res_of` are both 1 when the high half differs from w copies of bit w-1 of the low half, and both 0 otherwise.
- R9: `res_cf` and `res_of` change only in a cycle where `res_valid` and `res_last` are both high. During a low-half beat they still show the previous operation's flags.
- R10: While `res_valid` is high and `res_ready` is low, `res_valid`, `res_data` and `res_last` stay unchanged on the next cycle.
- R11: After reset, `req_ready` is 1, `res_valid` is 0, and `res_cf` and `res_of` are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Unit idle, request can be taken |
| req_signed | input | 1 | 1 = signed operands, 0 = unsigned |
| req_wsel | input | 2 | Operand width code: 0=8, 1=16, 2=32, 3=64 bits |
| req_keep_hi | input | 1 | 1 = deliver the high half as a second beat (widths above 8) |
| req_a | input | DW | First factor |
| req_b | input | DW | Second factor |
| res_valid | output | 1 | Result beat present |
| res_ready | input | 1 | Consumer takes the beat |
| res_data | output | DW | Result beat data |
| res_last | output | 1 | Final beat of the operation |
| res_cf | output | 1 | Carry flag, held until the next final beat |
| res_of | output | 1 | Overflow flag, held until the next final beat |

## Verification
Two events can fall in the same cycle. One is the flag update for an operation. The other is the handover between its low-half beat and its high-half beat: the edge that retires the low beat also presents the high beat and loads the new flags. The bench provokes this collision with `res_ready` held high, which retires the low beat at once. It also runs a phase of pseudo-random stalls, which stretches the low beat over many cycles and tests the hold rule too. Each low beat is judged against the previous operation's flags and each final beat against the new ones, with the most negative operand times -1 covered at every width.

// File: rtl/wmul_pkg.sv
package wmul_pkg;

  typedef enum logic [1:0] {
    WD_8  = 2'd0,
    WD_16 = 2'd1,
    WD_32 = 2'd2,
    WD_64 = 2'd3
  } wsel_e;

  typedef enum logic [1:0] {
    S_IDLE = 2'd0,
    S_RUN  = 2'd1,
    S_LO   = 2'd2,
    S_LAST = 2'd3
  } wmul_st_e;

  // operand width in bits for a width code
  function automatic logic [31:0] wsel_bits(input logic [1:0] code);
    return 32'd8 << code;
  endfunction

endpackage

// File: rtl/wmul_opnd.sv
// Operand conditioning: extends one factor from the selected width and
// returns its magnitude plus a negative marker.
module wmul_opnd #(
  parameter int unsigned DW = 64
) (
  input  logic [DW-1:0] val_i,
  input  logic [1:0]    wsel_i,
  input  logic          sgn_i,
  output logic [DW-1:0] mag_o,
  output logic          neg_o
);
  logic [31:0]   nb;
  logic [DW-1:0] mask;
  logic [DW-1:0] topv;
  logic [DW-1:0] ext;

  always_comb begin
    nb    = wmul_pkg::wsel_bits(wsel_i);
    mask  = {DW{1'b1}} >> (DW - nb);
    topv  = val_i >> (nb - 32'd1);
    neg_o = sgn_i & topv[0];
    ext   = (val_i & mask) | (neg_o ? ~mask : '0);
    mag_o = neg_o ? (~ext + 1'b1) : ext;
  end
endmodule

// File: rtl/wmul_iter.sv
// Iterative magnitude multiplier: STEP multiplier bits retired per clock.
module wmul_iter #(
  parameter int unsigned DW   = 64,
  parameter int unsigned STEP = 4
) (
  input  logic                              clk,
  input  logic                              rst,
  input  logic                              load_i,
  input  logic [DW-1:0]                     mc_i,
  input  logic [DW-1:0]                     mp_i,
  input  logic [$clog2(DW/STEP+1)-1:0]      steps_i,
  output logic                              done_o,
  output logic [2*DW-1:0]                   prod_o
);
  localparam int unsigned PW = 2 * DW;
  localparam int unsigned CW = $clog2(DW / STEP + 1);

  logic [PW-1:0] acc;
  logic [PW-1:0] mc;
  logic [DW-1:0] mp;
  logic [CW-1:0] cnt;
  logic          done_q;
  logic [PW-1:0] pp [STEP];
  logic [PW-1:0] sum;

  for (genvar j = 0; j < STEP; j++) begin : g_pp
    assign pp[j] = mp[j] ? (mc << j) : '0;
  end

  always_comb begin
    sum = acc;
    for (int j = 0; j < STEP; j++) begin
      sum = sum + pp[j];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      acc    <= '0;
      mc     <= '0;
      mp     <= '0;
      cnt    <= '0;
      done_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (load_i) begin
        acc <= '0;
        mc  <= {{DW{1'b0}}, mc_i};
        mp  <= mp_i;
        cnt <= steps_i;
      end else if (cnt != '0) begin
        acc <= sum;
        mc  <= mc << STEP;
        mp  <= mp >> STEP;
        cnt <= cnt - CW'(1);
        if (cnt == CW'(1)) done_q <= 1'b1;
      end
    end
  end

  assign done_o = done_q;
  assign prod_o = acc;
endmodule

// File: rtl/wmul_split.sv
// Sign restore, half split at the selected width, and the overflow rule.
module wmul_split #(
  parameter int unsigned DW = 64
) (
  input  logic [2*DW-1:0] prod_i,
  input  logic            neg_i,
  input  logic            sgn_i,
  input  logic [1:0]      wsel_i,
  output logic [DW-1:0]   lo_o,
  output logic [DW-1:0]   hi_o,
  output logic            ovf_o
);
  logic [31:0]     nb;
  logic [DW-1:0]   mask;
  logic [2*DW-1:0] p;
  logic [2*DW-1:0] up;
  logic [DW-1:0]   lotop;

  always_comb begin
    nb    = wmul_pkg::wsel_bits(wsel_i);
    mask  = {DW{1'b1}} >> (DW - nb);
    p     = neg_i ? (~prod_i + 1'b1) : prod_i;
    up    = p >> nb;
    lo_o  = p[DW-1:0] & mask;
    hi_o  = up[DW-1:0] & mask;
    lotop = lo_o >> (nb - 32'd1);
    if (sgn_i) ovf_o = (hi_o != (lotop[0] ? mask : '0));
    else       ovf_o = (hi_o != '0);
  end
endmodule

// File: rtl/wmul_unit.sv
module wmul_unit
  import wmul_pkg::*;
#(
  parameter int unsigned DW   = 64,
  parameter int unsigned STEP = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic          req_signed,
  input  logic [1:0]    req_wsel,
  input  logic          req_keep_hi,
  input  logic [DW-1:0] req_a,
  input  logic [DW-1:0] req_b,
  output logic          res_valid,
  input  logic          res_ready,
  output logic [DW-1:0] res_data,
  output logic          res_last,
  output logic          res_cf,
  output logic          res_of
);
  localparam int unsigned CW = $clog2(DW / STEP + 1);

  wmul_st_e      st;
  logic [1:0]    wsel_q;
  logic          sgn_q;
  logic          keep_q;
  logic          neg_q;
  logic [DW-1:0] lo_q;
  logic [DW-1:0] hi_q;
  logic          ovf_q;
  logic          cf_q;
  logic          of_q;

  logic [DW-1:0]   mag_a, mag_b;
  logic            neg_a, neg_b;
  logic            take;
  logic [CW-1:0]   steps;
  logic            it_done;
  logic [2*DW-1:0] it_prod;
  logic [DW-1:0]   sp_lo, sp_hi;
  logic            sp_ovf;
  logic            one_beat;

  wmul_opnd #(.DW(DW)) u_opa (
    .val_i(req_a), .wsel_i(req_wsel), .sgn_i(req_signed),
    .mag_o(mag_a), .neg_o(neg_a)
  );

  wmul_opnd #(.DW(DW)) u_opb (
    .val_i(req_b), .wsel_i(req_wsel), .sgn_i(req_signed),
    .mag_o(mag_b), .neg_o(neg_b)
  );

  assign take  = req_valid && req_ready;
  assign steps = CW'(wsel_bits(req_wsel) / STEP);

  wmul_iter #(.DW(DW), .STEP(STEP)) u_iter (
    .clk(clk), .rst(rst), .load_i(take),
    .mc_i(mag_a), .mp_i(mag_b), .steps_i(steps),
    .done_o(it_done), .prod_o(it_prod)
  );

  wmul_split #(.DW(DW)) u_split (
    .prod_i(it_prod), .neg_i(neg_q), .sgn_i(sgn_q), .wsel_i(wsel_q),
    .lo_o(sp_lo), .hi_o(sp_hi), .ovf_o(sp_ovf)
  );

  assign one_beat = (wsel_q == WD_8) || !keep_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      st     <= S_IDLE;
      wsel_q <= WD_8;
      sgn_q  <= 1'b0;
      keep_q <= 1'b0;
      neg_q  <= 1'b0;
      lo_q   <= '0;
      hi_q   <= '0;
      ovf_q  <= 1'b0;
      cf_q   <= 1'b0;
      of_q   <= 1'b0;
    end else begin
      unique case (st)
        S_IDLE: if (take) begin
          wsel_q <= req_wsel;
          sgn_q  <= req_signed;
          keep_q <= req_keep_hi;
          neg_q  <= neg_a ^ neg_b;
          st     <= S_RUN;
        end
        S_RUN: if (it_done) begin
          lo_q  <= sp_lo;
          hi_q  <= sp_hi;
          ovf_q <= sp_ovf;
          if (one_beat) begin
            cf_q <= sp_ovf;
            of_q <= sp_ovf;
            st   <= S_LAST;
          end else begin
            st   <= S_LO;
          end
        end
        S_LO: if (res_ready) begin
          cf_q <= ovf_q;
          of_q <= ovf_q;
          st   <= S_LAST;
        end
        S_LAST: if (res_ready) st <= S_IDLE;
        default: st <= S_IDLE;
      endcase
    end
  end

  always_comb begin
    res_data = '0;
    if (st == S_LO) begin
      res_data = lo_q;
    end else if (st == S_LAST) begin
      if (wsel_q == WD_8) res_data = DW'({hi_q[7:0], lo_q[7:0]});
      else if (keep_q)    res_data = hi_q;
      else                res_data = lo_q;
    end
  end

  assign req_ready = (st == S_IDLE);
  assign res_valid = (st == S_LO) || (st == S_LAST);
  assign res_last  = (st == S_LAST);
  assign res_cf    = cf_q;
  assign res_of    = of_q;
endmodule

// File: rtl/wmul_unit_chk.sv
module wmul_unit_chk #(
  parameter int unsigned DW = 64
) (
  input logic          clk,
  input logic          rst,
  input logic          req_valid,
  input logic          req_ready,
  input logic          res_valid,
  input logic          res_ready,
  input logic [DW-1:0] res_data,
  input logic          res_last,
  input logic          res_cf,
  input logic          res_of
);
  // R1: idle and presenting a result never overlap
  a_r1_no_overlap: assert property (@(posedge clk) disable iff (rst)
    req_ready |-> !res_valid);

  // R1: an accepted request closes the request port
  a_r1_busy_after_take: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_ready) |=> !req_ready);

  // R4: a retired low-half beat is followed at once by the final beat
  a_r4_high_follows: assert property (@(posedge clk) disable iff (rst)
    (res_valid && res_ready && !res_last) |=> (res_valid && res_last));

  // R9: flags move only while a final beat is on the port
  a_r9_flags_hold: assert property (@(posedge clk) disable iff (rst)
    !(res_valid && res_last) |-> ($stable(res_cf) && $stable(res_of)));

  // R10: a stalled beat holds still
  a_r10_stall_hold: assert property (@(posedge clk) disable iff (rst)
    (res_valid && !res_ready) |=>
      (res_valid && $stable(res_data) && $stable(res_last)));
endmodule

bind wmul_unit wmul_unit_chk #(.DW(DW)) u_chk (
  .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
  .res_valid(res_valid), .res_ready(res_ready), .res_data(res_data),
  .res_last(res_last), .res_cf(res_cf), .res_of(res_of)
);

// File: tb/sim_wmul_unit.sv
module sim_wmul_unit;
  localparam int CLK_PERIOD = 10;
  localparam int WDOG       = 150000;

  typedef struct {
    logic [63:0] data;
    logic        last;
    logic        flg;
    string       tag_d;
    string       tag_l;
    string       tag_f;
  } beat_t;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic        req_signed = 1'b0;
  logic [1:0]  req_wsel = 2'd0;
  logic        req_keep_hi = 1'b0;
  logic [63:0] req_a = '0;
  logic [63:0] req_b = '0;
  logic        res_valid;
  logic        res_ready = 1'b1;
  logic [63:0] res_data;
  logic        res_last;
  logic        res_cf;
  logic        res_of;

  int    errs = 0;
  int    checks = 0;
  bit    fin = 1'b0;
  bit    stall_on = 1'b0;
  logic  flag_prev = 1'b0;
  logic [63:0] rs = 64'h9E37_79B9_7F4A_7C15;
  beat_t sb[$];

  wmul_unit #(.DW(64), .STEP(4)) u0 (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
    .req_signed(req_signed), .req_wsel(req_wsel), .req_keep_hi(req_keep_hi),
    .req_a(req_a), .req_b(req_b), .res_valid(res_valid), .res_ready(res_ready),
    .res_data(res_data), .res_last(res_last), .res_cf(res_cf), .res_of(res_of)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [63:0] rnd();
    rs = rs ^ (rs << 13);
    rs = rs ^ (rs >> 7);
    rs = rs ^ (rs << 17);
    return rs;
  endfunction

  task automatic chk(input bit ok, input string tag, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s %s: actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  // reference model written from R2, R3, R7, R8
  task automatic ref_mul(input logic sgn, input logic [1:0] ws,
                         input logic [63:0] a, input logic [63:0] b,
                         output logic [63:0] lo, output logic [63:0] hi,
                         output logic ovf);
    int nb;
    logic [63:0] m;
    logic [127:0] ea, eb, p, up;
    nb = 8 << ws;
    m  = (nb == 64) ? 64'hFFFF_FFFF_FFFF_FFFF : ((64'd1 << nb) - 64'd1);
    ea = {64'd0, a & m};
    eb = {64'd0, b & m};
    if (sgn && a[nb-1]) ea = ea | ~{64'd0, m};
    if (sgn && b[nb-1]) eb = eb | ~{64'd0, m};
    p  = ea * eb;
    up = p >> nb;
    lo = p[63:0] & m;
    hi = up[63:0] & m;
    if (sgn) ovf = (hi != (lo[nb-1] ? m : 64'd0));
    else     ovf = (hi != 64'd0);
  endtask

  task automatic do_op(input logic sgn, input logic [1:0] ws, input logic keep,
                       input logic [63:0] a, input logic [63:0] b);
    logic [63:0] lo, hi;
    logic ovf;
    beat_t e;
    string td, tf;
    ref_mul(sgn, ws, a, b, lo, hi, ovf);
    td = sgn ? "R3" : "R2";
    tf = sgn ? "R8" : "R7";
    if (ws == 2'd0) begin
      e = '{{48'd0, hi[7:0], lo[7:0]}, 1'b1, ovf, {td, "/R6"}, "R6", tf};
      sb.push_back(e);
    end else if (keep) begin
      e = '{lo, 1'b0, flag_prev, {td, "/R4"}, "R4", "R9"};
      sb.push_back(e);
      e = '{hi, 1'b1, ovf, {td, "/R4"}, "R4", tf};
      sb.push_back(e);
    end else begin
      e = '{lo, 1'b1, ovf, {td, "/R5"}, "R5", {tf, "/R5"}};
      sb.push_back(e);
    end
    flag_prev = ovf;
    @(negedge clk);
    req_signed  = sgn;
    req_wsel    = ws;
    req_keep_hi = keep;
    req_a       = a;
    req_b       = b;
    req_valid   = 1'b1;
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    req_a     = rnd();
    req_b     = rnd();
    chk(req_ready == 1'b0, "R1", "ready after take", {63'd0, req_ready}, 64'd0);
  endtask

  // consumer back-pressure, changed just after each edge
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (stall_on) begin
        logic [63:0] r;
        r = rnd();
        res_ready = r[0] & r[5];
      end else begin
        res_ready = 1'b1;
      end
    end
  end

  // monitor: pops the scoreboard on every taken beat
  initial begin
    bit          hold_pend = 1'b0;
    logic [63:0] hold_d;
    logic        hold_l;
    forever begin
      @(negedge clk);
      if (!rst) begin
        if (hold_pend) begin
          chk(res_valid && res_data == hold_d && res_last == hold_l, "R10",
              "stalled beat", res_data, hold_d);
        end
        hold_pend = res_valid && !res_ready;
        hold_d    = res_data;
        hold_l    = res_last;
        if (res_valid) begin
          chk(!req_ready, "R1", "ready while result shown",
              {63'd0, req_ready}, 64'd0);
        end
        if (res_valid && res_ready) begin
          if (sb.size() == 0) begin
            chk(1'b0, "R1", "unexpected beat", res_data, 64'd0);
          end else begin
            beat_t e;
            e = sb.pop_front();
            chk(res_data == e.data, e.tag_d, "data", res_data, e.data);
            chk(res_last == e.last, e.tag_l, "last", {63'd0, res_last},
                {63'd0, e.last});
            chk(res_cf == e.flg && res_of == e.flg, e.tag_f, "cf/of",
                {62'd0, res_cf, res_of}, {62'd0, e.flg, e.flg});
          end
        end
      end
    end
  end

  initial begin
    repeat (WDOG) @(posedge clk);
    if (!fin) begin
      errs++;
      checks++;
      $display("FAIL R1 watchdog: actual=hung expected=completion");
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    // R11 reset state
    chk(req_ready == 1'b1, "R11", "req_ready", {63'd0, req_ready}, 64'd1);
    chk(res_valid == 1'b0, "R11", "res_valid", {63'd0, res_valid}, 64'd0);
    chk(res_cf == 1'b0 && res_of == 1'b0, "R11", "flags",
        {62'd0, res_cf, res_of}, 64'd0);

    // directed corners
    do_op(1'b0, 2'd0, 1'b1, 64'hFF, 64'hFF);
    do_op(1'b0, 2'd0, 1'b0, 64'h1234_5603, 64'hABCD_EF05);  // R2 upper bits ignored
    do_op(1'b1, 2'd0, 1'b1, 64'h80, 64'hFF);                 // R3 min * -1
    do_op(1'b1, 2'd1, 1'b1, 64'h8000, 64'hFFFF);
    do_op(1'b1, 2'd1, 1'b1, 64'hFFFE, 64'h0003);
    do_op(1'b1, 2'd2, 1'b0, 64'h8000_0000, 64'hFFFF_FFFF);   // R5 truncating
    do_op(1'b1, 2'd3, 1'b1, 64'h8000_0000_0000_0000, 64'hFFFF_FFFF_FFFF_FFFF);
    do_op(1'b0, 2'd3, 1'b1, 64'hFFFF_FFFF_FFFF_FFFF, 64'hFFFF_FFFF_FFFF_FFFF);
    do_op(1'b1, 2'd3, 1'b1, 64'hFFFF_FFFF_FFFF_FFFF, 64'hFFFF_FFFF_FFFF_FFFF);
    do_op(1'b0, 2'd2, 1'b1, 64'h0000_0000_0001_0000, 64'h0000_0000_0000_FFFF);
    do_op(1'b0, 2'd1, 1'b0, 64'h0000_0000_0000_0000, 64'h0000_0000_0000_1234);

    // random operations, first without stalls, then with stalls
    for (int k = 0; k < 300; k++) begin
      logic [63:0] r;
      r = rnd();
      if (k == 150) stall_on = 1'b1;
      do_op(r[0], r[2:1], r[3], rnd(), rnd());
    end
    // most negative times -1 at every width under stalls
    for (int w = 0; w < 4; w++) begin
      logic [63:0] mn;
      mn = 64'd1 << ((8 << w) - 1);
      do_op(1'b1, 2'(w), 1'b1, mn, 64'hFFFF_FFFF_FFFF_FFFF);
    end

    while (sb.size() != 0) @(negedge clk);
    repeat (4) @(negedge clk);
    chk(req_ready == 1'b1 && res_valid == 1'b0, "R1", "idle at end",
        {62'd0, req_ready, res_valid}, 64'd2);
    fin = 1'b1;
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule